// File: doc/BRIEF.md
# Reed-Solomon Syndrome Generator over a GF(4096) Tower Field

This block computes the eight syndromes of a Reed-Solomon codeword built from 12-bit symbols. Symbols arrive one per clock on a valid/ready stream. The stream carries a start marker on the first symbol of a codeword and an end marker on the last. Every accepted symbol updates all eight syndrome registers in parallel by Horner's rule, S_j <- S_j * beta_j XOR r, where beta_j = alpha^j for j = 0..7.

The arithmetic uses GF(2^12) built as a quadratic extension of GF(64). The base field is GF(2)[x]/(x^6 + x + 1). A 12-bit element is {h, l}, with h in bits 11:6 and l in bits 5:0. The extension polynomial is X^2 + X + A^-1, and A^-1 = 0x21 in the base field. The product of a and b has these halves:
- high half: m(ah^al, bh^bl) ^ m(al, bl)
- low half: m(m(ah, bh), 0x21) ^ m(al, bl)

The primitive element alpha is 0xE01 in this representation. Page codewords are 1367 symbols long, and the block accepts any length.

After the end marker, the syndromes are presented packed two per 32-bit word. An error flag is also presented. Both stay frozen until the next start marker is accepted.

Top module: `rs_syndrome_gf4096`

## Requirements
- R1: After reset, `syn_valid` and `syn_err` are 0, and every bit of `syn_words` is 0.
- R2: `in_ready` is 1 in every cycle after reset. A symbol is accepted in any cycle where `in_valid` is 1.
- R3: An accepted symbol r with `in_first` = 1 discards all previous state and sets every syndrome to r. This also holds when it arrives in the middle of a codeword.
- R4: An accepted symbol r with `in_first` = 0, while no result is held, updates each syndrome as S_j <- S_j * alpha^j XOR r. Multiplication is in the tower field given above, with alpha = 0xE01.
- R5: For a codeword r_0..r_{n-1}, the result is S_j = sum over i of r_i * alpha^(j*(n-1-i)), for j = 0..7. In particular, S_0 is the XOR of all symbols.
- R6: Syndromes are packed into `syn_words` as follows:
  - word k occupies bits 32k+31:32k;
  - S_2k sits in bits 32k+11:32k;
  - S_2k+1 sits in bits 32k+27:32k+16;
  - bits 15:12 and 31:28 of each word are 0.
- R7: `syn_valid` becomes 1 on the clock edge that accepts a symbol with `in_last` = 1. It is 0 after a start symbol that is not also an end symbol.
- R8: `syn_err` is 1 exactly when `syn_valid` is 1 and at least one syndrome is nonzero.
- R9: Cycles with `in_valid` = 0 change no state.
- R10: While `syn_valid` is 1, symbols without `in_first` are ignored. `syn_words`, `syn_valid` and `syn_err` keep their values until the next start symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Symbol present on `in_sym` |
| in_ready | output | 1 | Block can accept a symbol (always 1) |
| in_first | input | 1 | Symbol is the first of a codeword |
| in_last | input | 1 | Symbol is the last of a codeword |
| in_sym | input | 12 | Received 12-bit symbol |
| syn_valid | output | 1 | Syndromes of a completed codeword are held |
| syn_err | output | 1 | Held codeword has a nonzero syndrome |
| syn_words | output | 128 | Four packed words, two syndromes each |

## Verification
The bench sweeps all 4096 values of a leading symbol through two-symbol codewords. This exercises every input of the tower multiplier against each of the seven nontrivial roots. A wrong base polynomial, a wrong 0x21 constant or a swapped half would corrupt S_1..S_7 while leaving S_0 intact.

A full 1367-symbol codeword with idle gaps is checked against direct polynomial evaluation. A design that advanced on idle cycles, or used the wrong root exponents, would produce different syndromes.

Further checks cover the following cases, each of which a faulty design would get wrong:
- A restart in the middle of a codeword must discard the old state. A design that ignores it would mix two codewords.
- A single symbol carrying both markers must load and complete in one cycle.
- Stray symbols after the end marker must leave the held result untouched. A design that kept accumulating would change the held result.
- An all-zero codeword must leave the error flag low.

// File: rtl/rs_syndrome_gf4096.sv
module rs_syndrome_gf4096 #(
  parameter int          NSYN  = 8,
  parameter logic [11:0] ALPHA = 12'hE01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic [11:0]          in_sym,
  output logic                 syn_valid,
  output logic                 syn_err,
  output logic [NSYN*16-1:0]   syn_words
);

  localparam int NWORD = NSYN / 2;

  function automatic logic [5:0] mul64(input logic [5:0] a, input logic [5:0] b);
    logic [5:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 6; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[4:0], 1'b0} ^ (x[5] ? 6'h03 : 6'h00);
    end
    return p;
  endfunction

  function automatic logic [11:0] mul4k(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] hi, lo, ll;
    ll = mul64(a[5:0], b[5:0]);
    hi = mul64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ ll;
    lo = mul64(mul64(a[11:6], b[11:6]), 6'h21) ^ ll;
    return {hi, lo};
  endfunction

  function automatic logic [11:0] root_of(input int j);
    logic [11:0] r;
    r = 12'h001;
    for (int k = 0; k < j; k++) r = mul4k(r, ALPHA);
    return r;
  endfunction

  logic [11:0] syn_q [NSYN];
  logic        held_q;
  logic        take;
  logic        any_nz;

  assign in_ready  = 1'b1;
  assign take      = in_valid && (in_first || !held_q);
  assign syn_valid = held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= 1'b0;
    else if (take) held_q <= in_last;
  end

  for (genvar j = 0; j < NSYN; j++) begin : g_syn
    localparam logic [11:0] ROOT = root_of(j);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        syn_q[j] <= '0;
      else if (take)     syn_q[j] <= in_first ? in_sym : (mul4k(syn_q[j], ROOT) ^ in_sym);
    end

    a_r3_first_loads: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_first |=> syn_q[j] == $past(in_sym));
  end

  for (genvar k = 0; k < NWORD; k++) begin : g_pack
    assign syn_words[32*k +: 32] = {4'h0, syn_q[2*k+1], 4'h0, syn_q[2*k]};
  end

  always_comb begin
    any_nz = 1'b0;
    for (int j = 0; j < NSYN; j++) any_nz = any_nz | (|syn_q[j]);
  end
  assign syn_err = held_q && any_nz;

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(syn_words) && $stable(syn_valid));

  a_r10_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid && in_valid && !in_first |=> $stable(syn_words) && syn_valid);

  a_r7_done_rises: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last && (in_first || !syn_valid) |=> syn_valid);

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_first && !in_last |=> !syn_valid);

  a_r8_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    syn_err |-> syn_valid);

  a_r4_s0_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_first && !syn_valid |=> syn_q[0] == $past(syn_q[0] ^ in_sym));

endmodule

// File: tb/test_rs_syndrome_gf4096.sv
module test_rs_syndrome_gf4096;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [11:0] in_sym = '0;
  logic in_ready, syn_valid, syn_err;
  logic [127:0] syn_words;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [11:0] cw [0:2047];
  int          cw_len = 0;
  logic [11:0] beta [8];

  always #5 clk = ~clk;

  rs_syndrome_gf4096 i_rs_syndrome_gf4096 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_sym(in_sym),
    .syn_valid(syn_valid), .syn_err(syn_err), .syn_words(syn_words));

  function automatic logic [5:0] bm64(input logic [5:0] a, input logic [5:0] b);
    logic [6:0] r;
    r = '0;
    for (int i = 5; i >= 0; i--) begin
      r = {r[5:0], 1'b0};
      if (r[6]) r = r ^ 7'h43;
      if (b[i]) r = r ^ {1'b0, a};
    end
    return r[5:0];
  endfunction

  function automatic logic [11:0] bm4k(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] p_ll, p_hh, p_x;
    p_ll = bm64(a[5:0], b[5:0]);
    p_hh = bm64(a[11:6], b[11:6]);
    p_x  = bm64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]);
    return {p_x ^ p_ll, bm64(p_hh, 6'h21) ^ p_ll};
  endfunction

  function automatic logic [127:0] expect_words();
    logic [11:0] s [8];
    logic [11:0] p [8];
    logic [127:0] w;
    for (int j = 0; j < 8; j++) begin s[j] = '0; p[j] = 12'h001; end
    for (int i = cw_len - 1; i >= 0; i--)
      for (int j = 0; j < 8; j++) begin
        s[j] = s[j] ^ bm4k(cw[i], p[j]);
        p[j] = bm4k(p[j], beta[j]);
      end
    w = '0;
    for (int j = 0; j < 8; j++) w[16*j +: 12] = s[j];
    return w;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] s, input logic f, input logic l);
    in_valid = 1'b1; in_sym = s; in_first = f; in_last = l;
    if (f) cw_len = 0;
    cw[cw_len] = s;
    cw_len++;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic check_result(input string req);
    logic [127:0] e;
    e = expect_words();
    chk(req, syn_words, e);
    chk({req, "/R7 valid"}, {127'd0, syn_valid}, 128'd1);
    chk({req, "/R8 err"}, {127'd0, syn_err}, {127'd0, |e});
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [127:0] snap;
    beta[0] = 12'h001;
    for (int j = 1; j < 8; j++) beta[j] = bm4k(beta[j-1], 12'hE01);

    repeat (3) @(negedge clk);
    chk("R1 reset words", syn_words, '0);
    chk("R1 reset flags", {126'd0, syn_valid, syn_err}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready", {127'd0, in_ready}, 128'd1);

    // R3: single symbol carrying both markers
    send(12'hABC, 1'b1, 1'b1);
    chk("R3 single", syn_words, {4{4'h0, 12'hABC, 4'h0, 12'hABC}});
    check_result("R3 single");

    // R8: all-zero codeword
    for (int i = 0; i < 5; i++) send(12'h000, i == 0, i == 4);
    check_result("R8 zero codeword");

    // R4 R5 R6: exhaustive leading symbol sweep
    for (int a = 0; a < 4096; a++) begin
      send(12'(a), 1'b1, 1'b0);
      if (a == 7) chk("R7 mid codeword", {127'd0, syn_valid}, '0);
      send(12'(a) ^ 12'h5A5, 1'b0, 1'b1);
      check_result("R4 R5 R6 sweep");
    end

    // R3 restart mid codeword
    send(12'h111, 1'b1, 1'b0);
    send(12'h222, 1'b0, 1'b0);
    send(12'h333, 1'b1, 1'b0);
    send(12'h444, 1'b0, 1'b1);
    check_result("R3 restart");

    // R5 R9: full page with idle gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 1367; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[11:0], i == 0, i == 1366);
      if (lfsr[3:0] == 4'h0) repeat (2) @(negedge clk);
    end
    check_result("R5 R9 full page");

    // R10: stray symbols after end are ignored
    snap = syn_words;
    send(12'hFFF, 1'b0, 1'b0);
    send(12'h123, 1'b0, 1'b1);
    chk("R10 held words", syn_words, snap);
    chk("R10 held valid", {127'd0, syn_valid}, 128'd1);
    chk("R10 held err", {127'd0, syn_err}, {127'd0, |snap});

    // R6: reserved bits zero
    chk("R6 reserved", syn_words & {4{16'hF000, 16'hF000}}, '0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule